// File: doc/BRIEF.md
# Interrupt Vector and Status Unit

This block gathers the interrupt sources of a two-channel serial controller into one status register, compares them with a mask register and drives an active-low interrupt request. Each channel offers four sources: receiver ready without error, receiver ready with error, transmitter ready, and a catch-all for other sources. The status register follows the source levels, delayed by one clock.

When the host runs an interrupt-acknowledge cycle, the unit captures an 8-bit vector in the first clock of that cycle. It holds the vector on its vector output until the acknowledge ends. A 2-bit mode field picks how the vector is formed:

- no vector at all (the bus reads all ones);
- the programmed vector register as written;
- the programmed vector with the channel number spliced into bit 0;
- the programmed vector with a 2-bit interrupt-type code and the channel number spliced into its low bits.

A configuration bit picks whether a read of the status register returns raw status or status filtered by the mask. Register access uses a simple write port and a combinational read port.

Top module: `intvec_unit`

## Requirements
- R1: After reset, irq_n is 1, the configuration register reads 0, the mask reads 0, the vector register reads 0x0F and the status reads 0.
- R2: Register addresses are: 0 for configuration (bits 2:1 vector mode, bit 0 masked-read, bits 7:3 read as 0), 1 for the mask, 2 for the vector register and 3 for status, which is read-only and ignores writes. Status bit 4c+k belongs to channel c. Within a channel, k=0 is receiver without error, k=1 is receiver with error, k=2 is transmitter and k=3 is other. Status equals the src input as sampled at the previous clock edge.
- R3: When the masked-read bit is 1, a status read returns status AND mask. When it is 0, a status read returns the raw status whatever the mask holds.
- R4: irq_n is 0 exactly when (status AND mask) is non-zero, in either read mode.
- R5: At the clock edge where iack is high and was low at the previous edge, the vector is formed from the register values in force just before that edge. vec_o shows it from the next cycle and stays unchanged while iack remains high.
- R6: Vector mode 00 gives vec_o = 0xFF.
- R7: Vector mode 01 gives vec_o equal to the vector register.
- R8: Vector mode 10 gives vector register bits 7:1 with the selected channel number in bit 0.
- R9: Vector mode 11 gives vector register bits 7:3, the type code in bits 2:1 and the channel number in bit 0. The type codes are 11 for receiver with error, 10 for receiver without error, 01 for transmitter and 00 for other.
- R10: The selected channel is the lowest-numbered channel that has any pending (status AND mask) bit. Within that channel the type priority, highest first, is receiver with error, receiver without error, transmitter, other. With nothing pending, channel 0 and type 00 are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src | input | 8 | Interrupt source levels, 4 per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| iack | input | 1 | Interrupt-acknowledge cycle active |
| vec_o | output | 8 | Latched interrupt vector |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The start of an acknowledge cycle can share a clock edge with a register write to the vector, mask or configuration register, and with a change of the source levels. The bench raises iack in the same cycle as such a write and such a source change. The vector must then come from the values held before that edge: the old vector register and the old status, rather than the new ones. While iack stays high the sources keep moving, and the vector must not follow them. The behavioural model compares vec_o against its own captured value every cycle, so any leak of new data into the vector shows up.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int NCH    = 2;
  localparam int SRC_W  = 4;
  localparam int ST_W   = NCH * SRC_W;
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [1:0] {VM_NONE = 2'b00, VM_RAW = 2'b01,
                            VM_CHAN = 2'b10, VM_FULL = 2'b11} vmode_e;

  // source slot order inside one channel: 0 rx ok, 1 rx err, 2 tx, 3 other
  function automatic logic [1:0] type_code(input logic [SRC_W-1:0] p);
    if (p[1])      return 2'b11;
    else if (p[0]) return 2'b10;
    else if (p[2]) return 2'b01;
    else           return 2'b00;
  endfunction

  function automatic logic [7:0] build_vector(input vmode_e m, input logic [7:0] ivr,
                                              input logic chan, input logic [1:0] ty);
    case (m)
      VM_NONE: return 8'hFF;
      VM_RAW:  return ivr;
      VM_CHAN: return {ivr[7:1], chan};
      default: return {ivr[7:3], ty, chan};
    endcase
  endfunction
endpackage

// File: rtl/ivu_regs.sv
module ivu_regs
  import ivu_pkg::*;
#(
  parameter logic [7:0] IVR_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [ST_W-1:0] src,
  output vmode_e          vmode,
  output logic            mask_rd,
  output logic [ST_W-1:0] mask,
  output logic [7:0]      ivr,
  output logic [ST_W-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmode   <= VM_NONE;
      mask_rd <= 1'b0;
      mask    <= '0;
      ivr     <= IVR_RST;
      stat    <= '0;
    end else begin
      stat <= src;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            vmode   <= vmode_e'(wr_data[2:1]);
            mask_rd <= wr_data[0];
          end
          2'd1: mask <= wr_data[ST_W-1:0];
          2'd2: ivr  <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio
  import ivu_pkg::*;
(
  input  logic [ST_W-1:0] pend,
  output logic            chan,
  output logic [1:0]      ty
);
  logic [NCH-1:0] ch_any;
  logic [1:0]     ch_ty [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_any[c] = |pend[c*SRC_W +: SRC_W];
    assign ch_ty[c]  = type_code(pend[c*SRC_W +: SRC_W]);
  end

  always_comb begin
    chan = 1'b0;
    ty   = 2'b00;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (ch_any[c]) begin
        chan = c[0];
        ty   = ch_ty[c];
      end
    end
  end
endmodule

// File: rtl/ivu_ack.sv
module ivu_ack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iack,
  input  logic [7:0] vec_next,
  output logic       ack_start,
  output logic [7:0] vec_o
);
  logic iack_q;

  assign ack_start = iack && !iack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iack_q <= 1'b0;
      vec_o  <= 8'hFF;
    end else begin
      iack_q <= iack;
      if (ack_start) vec_o <= vec_next;
    end
  end
endmodule

// File: rtl/intvec_unit.sv
module intvec_unit
  import ivu_pkg::*;
#(
  parameter logic [7:0] IVR_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] src,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [1:0]      rd_addr,
  output logic [7:0]      rd_data,
  input  logic            iack,
  output logic [7:0]      vec_o,
  output logic            irq_n
);
  vmode_e          vmode;
  logic            mask_rd;
  logic [ST_W-1:0] mask;
  logic [7:0]      ivr;
  logic [ST_W-1:0] stat;
  logic [ST_W-1:0] pend;
  logic            sel_chan;
  logic [1:0]      sel_ty;
  logic [7:0]      vec_next;
  logic            ack_start;

  ivu_regs #(.IVR_RST(IVR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src(src), .vmode(vmode), .mask_rd(mask_rd), .mask(mask), .ivr(ivr), .stat(stat)
  );

  assign pend = stat & mask;

  ivu_prio u_prio (.pend(pend), .chan(sel_chan), .ty(sel_ty));

  assign vec_next = build_vector(vmode, ivr, sel_chan, sel_ty);

  ivu_ack u_ack (
    .clk(clk), .rst_n(rst_n), .iack(iack), .vec_next(vec_next),
    .ack_start(ack_start), .vec_o(vec_o)
  );

  assign irq_n = ~|pend;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {5'b0, vmode, mask_rd};
      2'd1:    rd_data = mask;
      2'd2:    rd_data = ivr;
      default: rd_data = mask_rd ? pend : stat;
    endcase
  end
endmodule

// File: rtl/ivu_chk.sv
module ivu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iack,
  input logic       ack_start,
  input logic [1:0] vmode,
  input logic       mask_rd,
  input logic [7:0] ivr,
  input logic [7:0] stat,
  input logic [7:0] mask,
  input logic [7:0] vec_o,
  input logic       irq_n,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data
);
  // R2
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 2'd0 |-> rd_data[7:3] == 5'b0);
  // R3
  masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3 && mask_rd) |-> (rd_data & ~mask) == 8'h00);
  // R4
  irq_on_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & mask)) |-> !irq_n);
  // R4
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & mask)) |-> irq_n);
  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !ack_start) |=> $stable(vec_o));
  // R6
  mode_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && vmode == 2'b00) |=> vec_o == 8'hFF);
  // R7
  mode_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && vmode == 2'b01) |=> vec_o == $past(ivr));
  // R8
  mode_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && vmode == 2'b10) |=> vec_o[7:1] == $past(ivr[7:1]));
  // R9
  mode_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && vmode == 2'b11) |=> vec_o[7:3] == $past(ivr[7:3]));
endmodule

bind intvec_unit ivu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iack(iack), .ack_start(ack_start), .vmode(vmode),
  .mask_rd(mask_rd), .ivr(ivr), .stat(stat), .mask(mask), .vec_o(vec_o),
  .irq_n(irq_n), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_intvec_unit.sv
module test_intvec_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = 8'h00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       iack = 1'b0;
  logic [7:0] vec_o;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  intvec_unit i_intvec_unit (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .iack(iack),
    .vec_o(vec_o), .irq_n(irq_n)
  );

  // behavioural reference
  int   m_mode;
  bit   m_mrd;
  int   m_mask, m_ivr, m_stat, m_vec, m_vmode_at_ack;
  bit   m_iack_d;

  function automatic int ref_vec(int mode, int ivr, int stat, int mask);
    int ch = 0, ty = 0;
    bit found = 0;
    int p;
    for (int c = 0; c < 2; c++) begin
      p = ((stat & mask) >> (4 * c)) & 15;
      if (!found && p != 0) begin
        found = 1; ch = c;
        if (p & 2)      ty = 3;
        else if (p & 1) ty = 2;
        else if (p & 4) ty = 1;
        else            ty = 0;
      end
    end
    if (mode == 0) return 255;
    if (mode == 1) return ivr;
    if (mode == 2) return (ivr & 254) + ch;
    return (ivr & 248) + ty * 2 + ch;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_mrd <= 0; m_mask <= 0; m_ivr <= 15; m_stat <= 0;
      m_vec <= 255; m_iack_d <= 0; m_vmode_at_ack <= 0;
    end else begin
      m_stat   <= src;
      m_iack_d <= iack;
      if (iack && !m_iack_d) begin
        m_vec <= ref_vec(m_mode, m_ivr, m_stat, m_mask);
        m_vmode_at_ack <= m_mode;
      end
      if (wr_en) begin
        if (wr_addr == 0) begin m_mode <= (wr_data >> 1) & 3; m_mrd <= wr_data[0]; end
        else if (wr_addr == 1) m_mask <= wr_data;
        else if (wr_addr == 2) m_ivr <= wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_read(int a);
    if (a == 0) return m_mode * 2 + m_mrd;
    if (a == 1) return m_mask;
    if (a == 2) return m_ivr;
    return m_mrd ? (m_stat & m_mask) : m_stat;
  endfunction

  // sample on the falling edge, then move rd_addr on
  task automatic tick();
    int e;
    @(negedge clk);
    if (rst_n) begin
      e = ((m_stat & m_mask) != 0) ? 0 : 1;
      chk(irq_n == e[0], "R4", irq_n, e);
      e = ref_read(rd_addr);
      chk(rd_data == e[7:0], (rd_addr == 3) ? "R3" : "R2", rd_data, e);
      if (iack && m_iack_d) begin
        case (m_vmode_at_ack)
          0: chk(vec_o == m_vec[7:0], "R6/R5", vec_o, m_vec);
          1: chk(vec_o == m_vec[7:0], "R7/R5", vec_o, m_vec);
          2: chk(vec_o == m_vec[7:0], "R8/R5", vec_o, m_vec);
          default: chk(vec_o == m_vec[7:0], "R9/R5", vec_o, m_vec);
        endcase
      end
    end
    rd_addr = rd_addr + 2'd1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  // raise iack, check the latched vector, disturb sources, drop iack
  task automatic ack_check(input logic [7:0] exp, input string req);
    iack = 1;
    tick();
    chk(vec_o == exp, req, vec_o, exp);
    src = ~src;
    tick(); tick();
    chk(vec_o == exp, "R5", vec_o, exp);
    iack = 0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state seen during reset
    chk(irq_n == 1'b1, "R1", irq_n, 1);
    rst_n = 1;
    rd_addr = 2'd2; #1;
    chk(rd_data == 8'h0F, "R1", rd_data, 8'h0F);
    rd_addr = 2'd0; #1;
    chk(rd_data == 8'h00, "R1", rd_data, 0);
    rd_addr = 2'd3; #1;
    chk(rd_data == 8'h00, "R1", rd_data, 0);
    repeat (4) tick();

    // R2 reserved bits, read-only status
    wr(2'd0, 8'hFF);
    rd_addr = 2'd0; #1;
    chk(rd_data == 8'h07, "R2", rd_data, 8'h07);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'hA5);
    src = 8'h5C; tick(); tick();

    // R3 raw vs masked
    wr(2'd0, 8'h00);
    rd_addr = 2'd3; #1;
    chk(rd_data == 8'h5C, "R3", rd_data, 8'h5C);
    chk(irq_n == 1'b1, "R4", irq_n, 1);
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h01);
    rd_addr = 2'd3; #1;
    chk(rd_data == 8'h0C, "R3", rd_data, 8'h0C);
    chk(irq_n == 1'b0, "R4", irq_n, 0);

    // mode 11: ch0 rx err + tx -> 0xA6
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h06);
    src = 8'h06; tick(); tick();
    ack_check(8'hA6, "R9");
    // mode 11: ch0 rx ok + tx -> type 10 (R10)
    src = 8'h05; tick(); tick();
    ack_check(8'hA4, "R10");
    // mode 11: ch1 tx only -> 0xA3
    src = 8'h40; tick(); tick();
    ack_check(8'hA3, "R9");
    // channel 0 other outranks channel 1 rx err (R10)
    src = 8'h28; tick(); tick();
    ack_check(8'hA0, "R10");
    // nothing pending -> ch0 type 00
    src = 8'h00; tick(); tick();
    ack_check(8'hA0, "R10");
    // mode 10: ch1 only -> 0xA5
    wr(2'd0, 8'h04);
    src = 8'h20; tick(); tick();
    ack_check(8'hA5, "R8");
    // mode 01
    wr(2'd0, 8'h02);
    ack_check(8'hA5, "R7");
    // mode 00
    wr(2'd0, 8'h00);
    src = 8'h11; tick(); tick();
    ack_check(8'hFF, "R6");

    // R5: ack start shares an edge with a vector write and source change
    wr(2'd0, 8'h06);
    src = 8'h02; tick(); tick();
    wr_en = 1; wr_addr = 2'd2; wr_data = 8'h3C; iack = 1; src = 8'h40;
    tick();
    wr_en = 0;
    chk(vec_o == 8'hA6, "R5", vec_o, 8'hA6);
    tick();
    chk(vec_o == 8'hA6, "R5", vec_o, 8'hA6);
    iack = 0; tick();
    ack_check(8'h3B, "R9");

    // masked-off sources do not raise irq (R4)
    wr(2'd1, 8'h0F);
    src = 8'hF0; tick(); tick();
    chk(irq_n == 1'b1, "R4", irq_n, 1);

    for (int i = 0; i < 40; i++) begin
      src = 8'((i * 37) ^ (i << 2));
      if (i % 5 == 0) wr(2'd1, 8'(i * 13));
      iack = (i % 7) > 2;
      tick();
    end
    iack = 0; tick();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule